// File: doc/BRIEF.md
# Energy Meter Pulse Output Generator

This block turns per-interval energy rate values into output pulse trains for a metering front end. Each of four channels holds a 32-bit phase accumulator. On every slow timing tick the channel adds its rate to the accumulator, and every carry out of the accumulator stands for one quantum of energy. Two channels shape each carry into a pulse of programmable width. The other two channels toggle on every carry, which gives a square wave with a 50% duty cycle at half the carry rate.

Rates come from one of two sources, chosen by `src_host`. The internal post-processing path presents a full set of rates with the `ready` strobe, and those rates take over at the next interval boundary. A host writes single channel rates into a shadow bank. The shadow is staged only at the next `ready` after the write and goes live at the boundary after that, one interval later than internal data. The idle level of every output is sampled from `pulse_init` while reset is high. An active pulse drives the opposite level.

Top module: `meter_pulse_gen`

## Requirements
- R1: While `rst` is high, the block samples `pulse_init` and every output settles to that level. After reset each output rests at that level when idle, and later changes on `pulse_init` have no effect.
- R2: On a `ready` strobe the block stages the `int_rate` vector. The staged rates apply from the next `intv_end` strobe when `src_host` is 0. Ticks before that boundary still use the previous rates.
- R3: A host write sets `host_data` into channel `host_addr`, where channel 0 and 1 are `pulse_fixed[0..1]` and channel 2 and 3 are `pulse_half[0..1]`. The shadow is staged at the first `ready` after the write and applies at the `intv_end` that follows, when `src_host` is 1. A boundary that comes before that `ready` leaves the rates unchanged.
- R4: Each tick adds the channel rate to its 32-bit accumulator, and a carry out produces one output event. Without a tick, no output changes.
- R5: A pulse on a fixed-width output starts on the tick that carries. It drives the inverse of the idle level for 2×`width_cfg`+1 ticks.
- R6: A change of `width_cfg` during a pulse leaves that pulse's length unchanged. The new width applies from the next pulse on.
- R7: Carries that arrive during a pulse are counted and emitted later as further pulses, at least one tick apart, and none is dropped.
- R8: Each 50%-duty output toggles on every carry of its channel, whatever the value of `width_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_init | input | 1 | Idle output level, sampled during reset |
| tick | input | 1 | Single-cycle timing tick enable |
| intv_end | input | 1 | Single-cycle accumulation interval boundary |
| ready | input | 1 | Single-cycle post-processing done strobe |
| src_host | input | 1 | 1 selects host rates, 0 selects internal rates |
| int_rate | input | 128 | Internal rates, channel n in bits [32n+31:32n] |
| host_wr | input | 1 | Host rate write strobe |
| host_addr | input | 2 | Host write channel index |
| host_data | input | 32 | Host write rate |
| width_cfg | input | 8 | Fixed pulse width code |
| pulse_fixed | output | 2 | Fixed-width pulse outputs |
| pulse_half | output | 2 | 50%-duty outputs |

## Verification
Backlog behaviour (R7) is the hardest case to reach from the ports. It needs carries that arrive faster than a pulse can finish. The stimulus sets a rate of half full scale, so the accumulator carries on every second tick, together with a three-tick width. A queue builds up this way, and the bench then shrinks the width in the middle of a pulse, which checks R6 and the queued pulses in the same run. The host path is exercised with a boundary placed before `ready`, which shows the extra interval of latency.

// File: rtl/emp_pkg.sv
package emp_pkg;
    localparam int WIDTH_W   = 8;
    localparam int BACKLOG_W = 6;
    localparam int REMAIN_W  = WIDTH_W + 1;

    typedef struct packed {
        logic                 active;
        logic [REMAIN_W-1:0]  remain;
        logic [BACKLOG_W-1:0] backlog;
    } fix_state_t;

    function automatic logic [REMAIN_W-1:0] pulse_ticks(input logic [WIDTH_W-1:0] code);
        return {code, 1'b1};
    endfunction
endpackage

// File: rtl/emp_rate_loader.sv
module emp_rate_loader #(
    parameter int NCH    = 4,
    parameter int RATE_W = 32,
    localparam int AW    = $clog2(NCH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  intv_end,
    input  logic                  ready,
    input  logic                  src_host,
    input  logic [NCH*RATE_W-1:0] int_rate,
    input  logic                  host_wr,
    input  logic [AW-1:0]         host_addr,
    input  logic [RATE_W-1:0]     host_data,
    output logic [NCH*RATE_W-1:0] live_rate
);
    logic [NCH-1:0][RATE_W-1:0] shadow_q;
    logic [NCH*RATE_W-1:0]      int_stage_q;
    logic [NCH*RATE_W-1:0]      host_stage_q;
    logic                       pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q     <= '0;
            int_stage_q  <= '0;
            host_stage_q <= '0;
            pend_q       <= 1'b0;
            live_rate    <= '0;
        end else begin
            if (ready) begin
                int_stage_q <= int_rate;
                if (pend_q) begin
                    host_stage_q <= shadow_q;
                end
            end
            if (host_wr) begin
                shadow_q[host_addr] <= host_data;
                pend_q <= 1'b1;
            end else if (ready) begin
                pend_q <= 1'b0;
            end
            if (intv_end) begin
                live_rate <= src_host ? host_stage_q : int_stage_q;
            end
        end
    end
endmodule

// File: rtl/emp_phase_acc.sv
module emp_phase_acc #(
    parameter int RATE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    output logic              carry
);
    logic [RATE_W-1:0] acc_q;
    logic [RATE_W:0]   sum_w;

    assign sum_w = {1'b0, acc_q} + {1'b0, rate};
    assign carry = tick & sum_w[RATE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (tick) begin
            acc_q <= sum_w[RATE_W-1:0];
        end
    end
endmodule

// File: rtl/emp_fixed_shaper.sv
module emp_fixed_shaper
    import emp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               carry,
    input  logic [WIDTH_W-1:0] width_cfg,
    output logic               active
);
    localparam logic [BACKLOG_W-1:0] BL_MAX  = '1;
    localparam logic [REMAIN_W-1:0]  LAST_ONE = REMAIN_W'(1);

    fix_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (tick) begin
            if (st_q.active) begin
                if (st_q.remain == LAST_ONE) begin
                    st_q.active <= 1'b0;
                end else begin
                    st_q.remain <= st_q.remain - 1'b1;
                end
                if (carry && st_q.backlog != BL_MAX) begin
                    st_q.backlog <= st_q.backlog + 1'b1;
                end
            end else if (carry || st_q.backlog != '0) begin
                st_q.active <= 1'b1;
                st_q.remain <= pulse_ticks(width_cfg);
                if (!carry) begin
                    st_q.backlog <= st_q.backlog - 1'b1;
                end
            end
        end
    end

    assign active = st_q.active;
endmodule

// File: rtl/meter_pulse_gen.sv
module meter_pulse_gen
    import emp_pkg::*;
#(
    parameter int NFIX   = 2,
    parameter int NHALF  = 2,
    parameter int RATE_W = 32,
    localparam int NCH   = NFIX + NHALF,
    localparam int AW    = $clog2(NCH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pulse_init,
    input  logic                  tick,
    input  logic                  intv_end,
    input  logic                  ready,
    input  logic                  src_host,
    input  logic [NCH*RATE_W-1:0] int_rate,
    input  logic                  host_wr,
    input  logic [AW-1:0]         host_addr,
    input  logic [RATE_W-1:0]     host_data,
    input  logic [WIDTH_W-1:0]    width_cfg,
    output logic [NFIX-1:0]       pulse_fixed,
    output logic [NHALF-1:0]      pulse_half
);
    logic                  idle_q;
    logic [NCH*RATE_W-1:0] live_rate;
    logic [NCH-1:0]        carry;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= pulse_init;
        end
    end

    emp_rate_loader #(.NCH(NCH), .RATE_W(RATE_W)) u_loader (
        .clk(clk), .rst(rst), .intv_end(intv_end), .ready(ready),
        .src_host(src_host), .int_rate(int_rate), .host_wr(host_wr),
        .host_addr(host_addr), .host_data(host_data), .live_rate(live_rate)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_acc
        emp_phase_acc #(.RATE_W(RATE_W)) u_acc (
            .clk(clk), .rst(rst), .tick(tick),
            .rate(live_rate[c*RATE_W +: RATE_W]), .carry(carry[c])
        );
    end

    for (genvar f = 0; f < NFIX; f++) begin : g_fix
        logic act;
        emp_fixed_shaper u_shape (
            .clk(clk), .rst(rst), .tick(tick), .carry(carry[f]),
            .width_cfg(width_cfg), .active(act)
        );
        assign pulse_fixed[f] = idle_q ^ act;
    end

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        logic tog_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                tog_q <= 1'b0;
            end else if (carry[NFIX+h]) begin
                tog_q <= ~tog_q;
            end
        end
        assign pulse_half[h] = idle_q ^ tog_q;
    end
endmodule

// File: rtl/emp_pulse_checker.sv
module emp_pulse_checker #(
    parameter int NFIX   = 2,
    parameter int NHALF  = 2,
    parameter int RATE_W = 32,
    localparam int NCH   = NFIX + NHALF
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  tick,
    input logic                  intv_end,
    input logic                  idle_q,
    input logic [NCH*RATE_W-1:0] live_rate,
    input logic [NFIX-1:0]       pulse_fixed,
    input logic [NHALF-1:0]      pulse_half
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    a_r1_idle_level_held: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> $stable(idle_q));

    a_r2_rate_only_at_boundary: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(intv_end)) |-> $stable(live_rate));

    a_r4_quiet_without_tick: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(tick)) |-> ($stable(pulse_fixed) && $stable(pulse_half)));

    for (genvar h = 0; h < NHALF; h++) begin : g_chk
        a_r8_zero_rate_no_toggle: assert property (@(posedge clk) disable iff (rst)
            (past_ok && $past(live_rate[(NFIX+h)*RATE_W +: RATE_W]) == '0)
            |-> $stable(pulse_half[h]));
    end
endmodule

bind meter_pulse_gen emp_pulse_checker #(.NFIX(NFIX), .NHALF(NHALF), .RATE_W(RATE_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .intv_end(intv_end), .idle_q(idle_q),
    .live_rate(live_rate), .pulse_fixed(pulse_fixed), .pulse_half(pulse_half)
);

// File: tb/meter_pulse_gen_test.sv
module meter_pulse_gen_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pulse_init = 1'b1;
    logic         tick = 1'b0;
    logic         intv_end = 1'b0;
    logic         ready = 1'b0;
    logic         src_host = 1'b0;
    logic [127:0] int_rate = '0;
    logic         host_wr = 1'b0;
    logic [1:0]   host_addr = '0;
    logic [31:0]  host_data = '0;
    logic [7:0]   width_cfg = '0;
    logic [1:0]   pulse_fixed;
    logic [1:0]   pulse_half;

    always #10 clk = ~clk;

    meter_pulse_gen uut (
        .clk(clk), .rst(rst), .pulse_init(pulse_init), .tick(tick),
        .intv_end(intv_end), .ready(ready), .src_host(src_host),
        .int_rate(int_rate), .host_wr(host_wr), .host_addr(host_addr),
        .host_data(host_data), .width_cfg(width_cfg),
        .pulse_fixed(pulse_fixed), .pulse_half(pulse_half)
    );

    typedef struct {
        string      tag;
        logic [3:0] exp;
    } item_t;

    item_t queue_q[$];
    event  smp;
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    localparam logic [31:0] HALF_FS = 32'h8000_0000;
    localparam logic [31:0] QRTR_FS = 32'h4000_0000;

    // monitor: pops one expected item per sample event
    initial begin
        forever begin
            @(smp);
            while (queue_q.size() > 0) begin
                item_t it;
                logic [3:0] got;
                it  = queue_q.pop_front();
                got = {pulse_half, pulse_fixed};
                checks++;
                if (got !== it.exp) begin
                    fails++;
                    $display("FAIL %s: got %b expected %b", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic push(input string tag, input logic [3:0] exp);
        item_t it;
        it.tag = tag;
        it.exp = exp;
        queue_q.push_back(it);
    endtask

    task automatic strobe(ref logic s);
        @(negedge clk) s = 1'b1;
        @(negedge clk) s = 1'b0;
    endtask

    // one tick, then compare {half[1],half[0],fixed[1],fixed[0]}
    task automatic tick_exp(input string tag, input logic [3:0] exp);
        push(tag, exp);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        -> smp;
        #1;
    endtask

    task automatic check_now(input string tag, input logic [3:0] exp);
        @(negedge clk);
        push(tag, exp);
        -> smp;
        #1;
    endtask

    task automatic do_reset(input logic lvl);
        @(negedge clk);
        rst = 1'b1;
        pulse_init = lvl;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        pulse_init = ~lvl;  // must not matter after reset (R1)
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // ---- scenario A: internal path, idle high, width 1 tick
        do_reset(1'b1);
        check_now("R1 idle high after reset", 4'b1111);
        tick_exp("R4 zero rate no carry", 4'b1111);
        tick_exp("R4 zero rate no carry", 4'b1111);
        int_rate = {QRTR_FS, HALF_FS, QRTR_FS, HALF_FS};
        strobe(ready);
        tick_exp("R2 staged rate not yet live", 4'b1111);
        tick_exp("R2 staged rate not yet live", 4'b1111);
        strobe(intv_end);
        tick_exp("R4 first add no carry", 4'b1111);
        tick_exp("R5 R8 carry on half rate", 4'b1010);
        tick_exp("R5 one tick width ends", 4'b1011);
        tick_exp("R4 R8 all channels carry", 4'b0100);

        // ---- scenario B: width 3 ticks, backlog, width change mid pulse
        int_rate = {32'h0, 32'h0, 32'h0, HALF_FS};
        strobe(ready);
        strobe(intv_end);
        width_cfg = 8'd1;
        tick_exp("R5 previous pulse ends", 4'b0111);
        tick_exp("R5 pulse starts", 4'b0110);
        tick_exp("R5 pulse held", 4'b0110);
        tick_exp("R7 carry during pulse queued", 4'b0110);
        tick_exp("R5 three tick width ends", 4'b0111);
        tick_exp("R7 queued pulse emitted", 4'b0110);
        width_cfg = 8'd0;
        tick_exp("R6 old width kept", 4'b0110);
        tick_exp("R6 old width kept", 4'b0110);
        tick_exp("R6 pulse ends after old width", 4'b0111);
        tick_exp("R7 backlog pulse new width", 4'b0110);
        tick_exp("R6 new width one tick", 4'b0111);
        tick_exp("R7 next pulse", 4'b0110);

        // ---- scenario C: host path, idle low
        do_reset(1'b0);
        check_now("R1 idle low after reset", 4'b0000);
        src_host = 1'b1;
        int_rate = {4{HALF_FS}};
        @(negedge clk);
        host_addr = 2'd1;
        host_data = HALF_FS;
        strobe(host_wr);
        strobe(intv_end);
        tick_exp("R3 boundary before ready ignored", 4'b0000);
        tick_exp("R3 boundary before ready ignored", 4'b0000);
        strobe(ready);
        tick_exp("R3 staged not live", 4'b0000);
        tick_exp("R3 staged not live", 4'b0000);
        strobe(intv_end);
        tick_exp("R3 live first add", 4'b0000);
        tick_exp("R3 R1 host rate pulse high", 4'b0010);
        tick_exp("R3 pulse ends", 4'b0000);
        tick_exp("R3 host rate pulse again", 4'b0010);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule